// File: doc/BRIEF.md
# Bootstrap Refresh Start-Up Sequencer

This block is the shared start-up controller for a three-phase half-bridge gate driver. It watches a digital undervoltage flag and a disable input. While either one is active it keeps every gate switch off. When both clear, it runs a refresh interval before normal switching is allowed. During that interval all low-side switches are on and all high-side switches are held off, so the bootstrap capacitors of the high-side drivers can charge.

The interval length is a cycle count, sampled when the interval starts. A count of zero skips the interval. After the interval, the per-phase high-side and low-side requests from the dead-time logic pass straight to the gates. The three mode indications are also brought out, so that neighbouring logic can see which force is in effect. At the 125 MHz reference clock, a count of about 188 gives an interval of about 1.5 µs.

Top module: `bridge_refresh_seq`

## Requirements
- R1: While `uv_flag` or `dis_in` is 1, every bit of `hi_gate` and `lo_gate` is 0 and `force_off` is 1 in that same cycle, whatever state the sequencer is in.
- R2: After reset the sequencer is in the off state: `force_off`=1, `force_low_on`=0, `run_en`=0, and all gates are 0.
- R3: When `uv_flag` and `dis_in` are both 0 in a cycle in the off state with `rfsh_len`=N>0, the following N cycles are refresh cycles: `force_low_on`=1, `lo_gate`=3'b111 and `hi_gate`=3'b000.
- R4: During refresh cycles, the values on `hi_req` and `lo_req` have no effect on the gates.
- R5: The cycle after the last refresh cycle is a run cycle: `run_en`=1, `hi_gate`=`hi_req` and `lo_gate`=`lo_req`, bit i driving phase i. Both switches of a phase may be on together when both are requested.
- R6: If `rfsh_len` is 0 when the sequencer leaves the off state, it goes straight to run in the next cycle, with no refresh cycle.
- R7: If `uv_flag` or `dis_in` is asserted during a refresh, the refresh is cancelled. When the next release happens, a complete interval of the then-current `rfsh_len` is run.
- R8: `rfsh_len` is sampled only when a refresh begins. Changes to it during a refresh do not alter that refresh's length.
- R9: Exactly one of `force_off`, `force_low_on` and `run_en` is 1 in every cycle. The all-off force takes priority over refresh, and refresh takes priority over run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| uv_flag | input | 1 | Supply below threshold when 1 |
| dis_in | input | 1 | Disable request when 1 |
| rfsh_len | input | 16 | Refresh interval length in cycles |
| hi_req | input | 3 | Per-phase high-side request from the dead-time logic |
| lo_req | input | 3 | Per-phase low-side request from the dead-time logic |
| force_off | output | 1 | All-off force in effect |
| force_low_on | output | 1 | Refresh force in effect (all low sides on) |
| run_en | output | 1 | Normal request-driven mode |
| hi_gate | output | 3 | High-side gate commands |
| lo_gate | output | 3 | Low-side gate commands |

## Verification
A scoreboard predicts the mode and the gate values of every cycle. Release is tried with interval lengths of 4, 1 and 0. These show whether the refresh window is exactly N cycles long and whether the zero-length bypass works. The undervoltage flag and the disable input are each asserted once in run and once in refresh, with conflicting requests held on the inputs. These cases show that the off force acts in the same cycle, that the off force overrides refresh, and that a cancelled refresh restarts in full. The interval length is changed while a refresh runs, and requests that contradict the refresh pattern are applied during refresh. Together these show that the length is latched when the refresh starts and that requests are ignored during refresh.

// File: rtl/bridge_refresh_pkg.sv
// Shared types for the bootstrap refresh sequencer.
// Assumes: three sequencer states, encoded in two bits.
package bridge_refresh_pkg;
    typedef enum logic [1:0] {
        SEQ_OFF     = 2'd0,
        SEQ_REFRESH = 2'd1,
        SEQ_RUN     = 2'd2
    } seq_state_e;
endpackage

// File: rtl/refresh_timer.sv
// Down-counter that measures the refresh interval.
// Assumes: load and dec are never asserted together. The length is
// captured on load only, so later input changes do not affect it.
module refresh_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             dec,
    input  logic [CNT_W-1:0] len,
    output logic             last
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    // Capture the length on load, then count down toward one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= len;
        end else if (dec && cnt_q != '0) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    // The final refresh cycle is the one in which the count reads one.
    assign last = (cnt_q == ONE);
endmodule

// File: rtl/seq_fsm.sv
// Off / refresh / run state machine, plus the mode indications.
// Assumes: uv and dis are already synchronous to clk. Either of them
// forces the off mode in the same cycle and sends the machine to off.
module seq_fsm #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             uv,
    input  logic             dis,
    input  logic [CNT_W-1:0] len,
    input  logic             tmr_last,
    output logic             tmr_load,
    output logic             tmr_dec,
    output logic             mode_off,
    output logic             mode_refresh,
    output logic             mode_run
);
    import bridge_refresh_pkg::*;

    seq_state_e state_q, state_d;
    logic       abort;

    assign abort = uv | dis;

    // Next-state selection. An abort wins from every state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_OFF:     state_d = (len == '0) ? SEQ_RUN : SEQ_REFRESH;
            SEQ_REFRESH: if (tmr_last) state_d = SEQ_RUN;
            SEQ_RUN:     state_d = SEQ_RUN;
            default:     state_d = SEQ_OFF;
        endcase
        if (abort) state_d = SEQ_OFF;
    end

    // State register; reset places the machine in off.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEQ_OFF;
        else        state_q <= state_d;
    end

    // Timer control: load when leaving off, count down while refreshing.
    assign tmr_load = (state_q == SEQ_OFF) && !abort;
    assign tmr_dec  = (state_q == SEQ_REFRESH) && !abort;

    // Mode flags. The off force is immediate and overrides the others.
    assign mode_off     = (state_q == SEQ_OFF) || abort;
    assign mode_refresh = (state_q == SEQ_REFRESH) && !abort;
    assign mode_run     = (state_q == SEQ_RUN) && !abort;
endmodule

// File: rtl/phase_gate.sv
// Gate override for one half-bridge phase.
// Assumes: at most one mode flag is set. If none is, the gates stay off.
module phase_gate (
    input  logic mode_off,
    input  logic mode_refresh,
    input  logic mode_run,
    input  logic hi_req,
    input  logic lo_req,
    output logic hi_gate,
    output logic lo_gate
);
    // Apply the forces in order: off first, then refresh, then requests.
    always_comb begin
        hi_gate = 1'b0;
        lo_gate = 1'b0;
        if (mode_off) begin
            hi_gate = 1'b0;
            lo_gate = 1'b0;
        end else if (mode_refresh) begin
            hi_gate = 1'b0;
            lo_gate = 1'b1;
        end else if (mode_run) begin
            hi_gate = hi_req;
            lo_gate = lo_req;
        end
    end
endmodule

// File: rtl/bridge_refresh_seq.sv
// Top level: start-up bootstrap refresh sequencer for a multi-phase bridge.
// Assumes: the per-phase requests come from dead-time logic upstream.
// This block only adds the all-off and refresh overrides.
module bridge_refresh_seq #(
    parameter int PHASES = 3,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              uv_flag,
    input  logic              dis_in,
    input  logic [CNT_W-1:0]  rfsh_len,
    input  logic [PHASES-1:0] hi_req,
    input  logic [PHASES-1:0] lo_req,
    output logic              force_off,
    output logic              force_low_on,
    output logic              run_en,
    output logic [PHASES-1:0] hi_gate,
    output logic [PHASES-1:0] lo_gate
);
    logic tmr_load, tmr_dec, tmr_last;

    seq_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .uv           (uv_flag),
        .dis          (dis_in),
        .len          (rfsh_len),
        .tmr_last     (tmr_last),
        .tmr_load     (tmr_load),
        .tmr_dec      (tmr_dec),
        .mode_off     (force_off),
        .mode_refresh (force_low_on),
        .mode_run     (run_en)
    );

    refresh_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .dec   (tmr_dec),
        .len   (rfsh_len),
        .last  (tmr_last)
    );

    for (genvar p = 0; p < PHASES; p++) begin : g_phase
        phase_gate u_gate (
            .mode_off     (force_off),
            .mode_refresh (force_low_on),
            .mode_run     (run_en),
            .hi_req       (hi_req[p]),
            .lo_req       (lo_req[p]),
            .hi_gate      (hi_gate[p]),
            .lo_gate      (lo_gate[p])
        );
    end
endmodule

// File: rtl/bridge_refresh_seq_chk.sv
// Property checker for the refresh sequencer, bound to the top module.
// Assumes: it observes only the ports of the top module.
module bridge_refresh_seq_chk #(
    parameter int PHASES = 3,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              uv_flag,
    input logic              dis_in,
    input logic [CNT_W-1:0]  rfsh_len,
    input logic [PHASES-1:0] hi_req,
    input logic [PHASES-1:0] lo_req,
    input logic              force_off,
    input logic              force_low_on,
    input logic              run_en,
    input logic [PHASES-1:0] hi_gate,
    input logic [PHASES-1:0] lo_gate
);
    // R1
    abort_gates_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uv_flag || dis_in) |-> (force_off && hi_gate == '0 && lo_gate == '0));

    // R9
    one_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({force_off, force_low_on, run_en}) == 1);

    // R3
    refresh_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
        force_low_on |-> (lo_gate == '1 && hi_gate == '0));

    // R5
    run_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_en |-> (hi_gate == hi_req && lo_gate == lo_req));

    // R3
    release_to_refresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (force_off && !uv_flag && !dis_in && rfsh_len != '0) |=>
        (force_low_on || uv_flag || dis_in));

    // R6
    release_to_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (force_off && !uv_flag && !dis_in && rfsh_len == '0) |=>
        (run_en || uv_flag || dis_in));
endmodule

bind bridge_refresh_seq bridge_refresh_seq_chk #(.PHASES(PHASES), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/bridge_refresh_seq_tb.sv
// Scoreboard bench for the refresh sequencer.
// The driver applies one cycle of stimulus and queues the expected mode.
// The monitor compares the outputs at the falling edge.
module bridge_refresh_seq_tb;
    localparam int M_OFF = 0;
    localparam int M_REF = 1;
    localparam int M_RUN = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        uv_flag = 1'b1;
    logic        dis_in = 1'b1;
    logic [15:0] rfsh_len = '0;
    logic [2:0]  hi_req = '0;
    logic [2:0]  lo_req = '0;
    logic        force_off, force_low_on, run_en;
    logic [2:0]  hi_gate, lo_gate;

    int checks = 0;
    int bad = 0;
    bit done = 1'b0;

    typedef struct {
        int         mode;
        logic [2:0] h;
        logic [2:0] l;
        string      tag;
    } item_t;

    item_t exp_q[$];

    always #4 clk = ~clk;

    bridge_refresh_seq u_dut (
        .clk(clk), .rst_n(rst_n), .uv_flag(uv_flag), .dis_in(dis_in),
        .rfsh_len(rfsh_len), .hi_req(hi_req), .lo_req(lo_req),
        .force_off(force_off), .force_low_on(force_low_on), .run_en(run_en),
        .hi_gate(hi_gate), .lo_gate(lo_gate)
    );

    // Drive one cycle of inputs and queue the expected outcome.
    task automatic cyc(input logic uv, input logic ds, input logic [15:0] len,
                       input logic [2:0] h, input logic [2:0] l,
                       input int mode, input string tag);
        item_t it;
        @(posedge clk);
        #1;
        uv_flag = uv; dis_in = ds; rfsh_len = len; hi_req = h; lo_req = l;
        it.mode = mode;
        it.tag  = tag;
        case (mode)
            M_REF:   begin it.h = 3'b000; it.l = 3'b111; end
            M_RUN:   begin it.h = h;      it.l = l;      end
            default: begin it.h = 3'b000; it.l = 3'b000; end
        endcase
        exp_q.push_back(it);
    endtask

    // Compare each queued item with the outputs in the middle of its cycle.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            item_t it;
            logic [2:0] fl, ef;
            it = exp_q.pop_front();
            fl = {force_off, force_low_on, run_en};
            ef = (it.mode == M_OFF) ? 3'b100 : (it.mode == M_REF) ? 3'b010 : 3'b001;
            checks++;
            if (fl !== ef || hi_gate !== it.h || lo_gate !== it.l) begin
                bad++;
                $display("FAIL %s: modes=%b hi=%b lo=%b expected modes=%b hi=%b lo=%b",
                         it.tag, fl, hi_gate, lo_gate, ef, it.h, it.l);
            end
        end
    end

    initial begin
        // R2: outputs during reset and right after it
        repeat (3) cyc(1, 1, 16'd4, 3'b111, 3'b111, M_OFF, "R2 reset");
        @(posedge clk); #1; rst_n = 1'b1;
        cyc(0, 1, 16'd4, 3'b101, 3'b010, M_OFF, "R1 dis held");
        cyc(1, 0, 16'd4, 3'b101, 3'b010, M_OFF, "R1 uv held");

        // R3 R5: release with a length of 4
        cyc(0, 0, 16'd4, 3'b101, 3'b010, M_OFF, "R3 release cycle");
        for (int i = 0; i < 4; i++)
            cyc(0, 0, 16'd4, 3'b101, 3'b000, M_REF, "R3 refresh window");
        cyc(0, 0, 16'd4, 3'b101, 3'b010, M_RUN, "R5 run pass");
        cyc(0, 0, 16'd4, 3'b011, 3'b011, M_RUN, "R5 run overlap");
        cyc(0, 0, 16'd4, 3'b000, 3'b111, M_RUN, "R5 run lows");

        // R1 R9: disable in run acts in the same cycle
        cyc(0, 1, 16'd4, 3'b111, 3'b111, M_OFF, "R1 R9 dis in run");
        // R6: zero length goes straight to run
        cyc(0, 0, 16'd0, 3'b110, 3'b001, M_OFF, "R6 release");
        cyc(0, 0, 16'd0, 3'b110, 3'b001, M_RUN, "R6 direct run");

        // R7 R8: cancel a refresh, then restart in full with a changing length
        cyc(1, 0, 16'd6, 3'b111, 3'b111, M_OFF, "R1 uv in run");
        cyc(0, 0, 16'd6, 3'b111, 3'b111, M_OFF, "R7 release");
        cyc(0, 0, 16'd6, 3'b111, 3'b000, M_REF, "R4 requests ignored");
        cyc(0, 0, 16'd6, 3'b010, 3'b101, M_REF, "R4 requests ignored");
        cyc(1, 0, 16'd6, 3'b010, 3'b101, M_OFF, "R7 R9 uv cancels refresh");
        cyc(0, 0, 16'd3, 3'b010, 3'b101, M_OFF, "R7 release again");
        cyc(0, 0, 16'd9, 3'b010, 3'b101, M_REF, "R8 len change");
        cyc(0, 0, 16'd1, 3'b010, 3'b101, M_REF, "R8 len change");
        cyc(0, 0, 16'd9, 3'b010, 3'b101, M_REF, "R7 full restart");
        cyc(0, 0, 16'd9, 3'b100, 3'b001, M_RUN, "R8 ends on latched len");

        // R3: length of one, with disable used to cancel run
        cyc(0, 1, 16'd1, 3'b100, 3'b001, M_OFF, "R1 dis");
        cyc(0, 0, 16'd1, 3'b100, 3'b001, M_OFF, "R3 release len1");
        cyc(0, 0, 16'd1, 3'b111, 3'b000, M_REF, "R3 single refresh");
        cyc(0, 0, 16'd1, 3'b001, 3'b100, M_RUN, "R5 run after len1");
        // R1: disable during refresh
        cyc(0, 1, 16'd5, 3'b001, 3'b100, M_OFF, "R1 dis");
        cyc(0, 0, 16'd5, 3'b001, 3'b100, M_OFF, "R3 release");
        cyc(0, 0, 16'd5, 3'b001, 3'b100, M_REF, "R3 refresh");
        cyc(0, 1, 16'd5, 3'b001, 3'b100, M_OFF, "R1 dis in refresh");

        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end
endmodule